// File: doc/BRIEF.md
# Interval Timer with Snapshot Capture

A 32-bit count-down interval timer on a small word-addressed register bus. Software loads a period in two 16-bit halves, picks single-shot or auto-reload behaviour, and starts or stops the timer with strobe bits in the control word. Each time the count expires, a sticky timeout flag is set. That flag, gated by an enable bit, drives a level interrupt output.

The running count is not readable directly. A write to either snapshot address copies the live count into a pair of 16-bit holding registers, and software then reads it back from those. The bus carries byte addresses, and the word is selected by the address shifted right by two. Reads take one cycle: read data appears on the clock edge after the one that samples the read enable.

Top module: `interval_timer`

## Requirements
- R1: After reset the six registers read zero, the interrupt output is low, the timer is stopped, and the count holds all ones. A snapshot taken right after reset gives 0xFFFF in both halves.
- R2: The word is taken from byte address bits [7:2], and bits [1:0] are ignored. Word map: 0 status, 1 control, 2 period low, 3 period high, 4 snapshot low, 5 snapshot high. Words above 5 read zero, and writes to them change nothing.
- R3: Control bit 0 is interrupt enable and bit 1 is auto-reload. Only these two bits are kept, and a control read returns zero in bits [31:2].
- R4: Control bit 2 is a start strobe and bit 3 is a stop strobe. Start takes effect only while stopped, and stop takes effect only while running. If both are set, the timer ends up stopped. While stopped, the count does not change.
- R5: While running, the count drops by one per clock. When it is zero, the next step sets the timeout flag (status bit 0) instead of decrementing, and the count reloads the period. The interval is therefore period+1 clocks.
- R6: On expiry with auto-reload set, the timer keeps running. With auto-reload clear, it clears the running flag (status bit 1) and holds the count at the period value.
- R7: A write to either period word keeps data bits [15:0], stops the timer, and loads the count with the new 32-bit period.
- R8: A write to word 4 or word 5 latches the current count, before that cycle's step: the low half goes to word 4 and the high half to word 5. Later reads return the latched values.
- R9: Any write to the status word clears the timeout flag, whatever the write data.
- R10: The interrupt output is high exactly when the timeout flag and the interrupt-enable bit are both set.
- R11: Read data is registered. It reflects the register state at the clock edge where the read enable is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Byte address |
| wrEn | input | 1 | Write enable |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read enable |
| rdData | output | 32 | Registered read data |
| irqOut | output | 1 | Level interrupt |

## Verification
The embedded properties assume that every bus input is a settled, known level at each rising edge. They also assume that a write and a read never target an address in the same cycle in a way that depends on ordering, since the read returns the state from before the write. The stimulus changes inputs only on falling edges and issues writes and reads as separate single-cycle transfers. Counter positions are predicted by counting edges from each start write, so snapshot and timeout checks land on known cycles.

// File: rtl/itimer_pkg.sv
package itimer_pkg;

  typedef enum logic [2:0] {
    REG_STAT = 3'd0,
    REG_CTRL = 3'd1,
    REG_PLO  = 3'd2,
    REG_PHI  = 3'd3,
    REG_SLO  = 3'd4,
    REG_SHI  = 3'd5
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       step;      // decrement this cycle
    logic       reload;    // expiry: load period
    logic [1:0] loadHalf;  // period half written
    logic       capture;   // latch count into snapshot
  } dpStrobe_t;

endpackage

// File: rtl/timer_datapath.sv
module timer_datapath
  import itimer_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strobe,
  input  logic [HALF_W-1:0]        wrHalf,
  output logic [1:0][HALF_W-1:0]   periodQ,
  output logic [1:0][HALF_W-1:0]   snapQ,
  output logic                     countZero
);

  localparam int CNT_W = 2 * HALF_W;

  logic [1:0][HALF_W-1:0] periodReg;
  logic [1:0][HALF_W-1:0] snapReg;
  logic [1:0][HALF_W-1:0] nextPeriod;
  logic [CNT_W-1:0]       cnt;
  logic                   anyLoad;

  assign anyLoad = |strobe.loadHalf;

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      nextPeriod[h] = strobe.loadHalf[h] ? wrHalf : periodReg[h];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg <= '0;
      snapReg   <= '0;
      cnt       <= '1;
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (strobe.loadHalf[h]) periodReg[h] <= wrHalf;
      end
      if (strobe.capture) snapReg <= cnt;
      if (anyLoad)             cnt <= nextPeriod;
      else if (strobe.reload)  cnt <= periodReg;
      else if (strobe.step)    cnt <= cnt - CNT_W'(1);
    end
  end

  assign periodQ   = periodReg;
  assign snapQ     = snapReg;
  assign countZero = (cnt == '0);

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !strobe.reload && !anyLoad |=> cnt == $past(cnt) - CNT_W'(1)); // R5

  AST_RELOAD_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload && !anyLoad |=> cnt == $past(periodReg)); // R6

  AST_SNAP_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> snapReg == $past(cnt)); // R8

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.step && !strobe.reload && !anyLoad |=> $stable(cnt)); // R4

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import itimer_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [WORD_AW-1:0] wordAddr,
  input  logic [3:0]         wrCmd,
  input  logic               countZero,
  output dpStrobe_t          strobe,
  output logic               ieBit,
  output logic               contBit,
  output logic               runFlag,
  output logic               toFlag,
  output logic               irqOut
);

  logic statWr, ctrlWr, loWr, hiWr, snapWr;
  logic startReq, stopReq, halt, step, expire;
  logic runNext;

  assign statWr = wrEn && (wordAddr == WORD_AW'(REG_STAT));
  assign ctrlWr = wrEn && (wordAddr == WORD_AW'(REG_CTRL));
  assign loWr   = wrEn && (wordAddr == WORD_AW'(REG_PLO));
  assign hiWr   = wrEn && (wordAddr == WORD_AW'(REG_PHI));
  assign snapWr = wrEn && ((wordAddr == WORD_AW'(REG_SLO)) ||
                           (wordAddr == WORD_AW'(REG_SHI)));

  assign startReq = ctrlWr && wrCmd[2];
  assign stopReq  = ctrlWr && wrCmd[3];
  assign halt     = stopReq || loWr || hiWr;
  assign step     = runFlag && !halt;
  assign expire   = step && countZero;

  always_comb begin
    runNext = runFlag;
    if (expire && !contBit) runNext = 1'b0;
    if (startReq && !runFlag) runNext = 1'b1;
    if (halt) runNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieBit   <= 1'b0;
      contBit <= 1'b0;
      runFlag <= 1'b0;
      toFlag  <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ieBit   <= wrCmd[0];
        contBit <= wrCmd[1];
      end
      runFlag <= runNext;
      if (expire)      toFlag <= 1'b1;
      else if (statWr) toFlag <= 1'b0;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.step     = step;
    strobe.reload   = expire;
    strobe.loadHalf = {hiWr, loWr};
    strobe.capture  = snapWr;
  end

  assign irqOut = ieBit && toFlag;

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !stopReq |=> runFlag); // R4

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !runFlag); // R4

  AST_PERIOD_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (loWr || hiWr) |=> !runFlag); // R7

  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rstN)
    expire && !contBit && !startReq |=> !runFlag && toFlag); // R6

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    statWr && !expire |=> !toFlag); // R9

  AST_TIMEOUT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toFlag) |-> $past(runFlag)); // R5

endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itimer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  wrEn,
  input  logic [2*HALF_W-1:0]   wrData,
  input  logic                  rdEn,
  output logic [2*HALF_W-1:0]   rdData,
  output logic                  irqOut
);

  localparam int DATA_W  = 2 * HALF_W;
  localparam int WORD_AW = ADDR_W - 2;

  logic [WORD_AW-1:0]      wordAddr;
  dpStrobe_t               strobe;
  logic [1:0][HALF_W-1:0]  periodQ, snapQ;
  logic                    countZero, ieBit, contBit, runFlag, toFlag;
  logic                    unusedBits;

  assign wordAddr   = busAddr[ADDR_W-1:2];
  assign unusedBits = ^{busAddr[1:0], wrData[DATA_W-1:HALF_W]};

  timer_ctrl #(.WORD_AW(WORD_AW)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wordAddr  (wordAddr),
    .wrCmd     (wrData[3:0]),
    .countZero (countZero),
    .strobe    (strobe),
    .ieBit     (ieBit),
    .contBit   (contBit),
    .runFlag   (runFlag),
    .toFlag    (toFlag),
    .irqOut    (irqOut)
  );

  timer_datapath #(.HALF_W(HALF_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrHalf    (wrData[HALF_W-1:0]),
    .periodQ   (periodQ),
    .snapQ     (snapQ),
    .countZero (countZero)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= '0;
      if (wordAddr == WORD_AW'(REG_STAT)) rdData[1:0] <= {runFlag, toFlag};
      if (wordAddr == WORD_AW'(REG_CTRL)) rdData[1:0] <= {contBit, ieBit};
      if (wordAddr == WORD_AW'(REG_PLO))  rdData[HALF_W-1:0] <= periodQ[0];
      if (wordAddr == WORD_AW'(REG_PHI))  rdData[HALF_W-1:0] <= periodQ[1];
      if (wordAddr == WORD_AW'(REG_SLO))  rdData[HALF_W-1:0] <= snapQ[0];
      if (wordAddr == WORD_AW'(REG_SHI))  rdData[HALF_W-1:0] <= snapQ[1];
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && (wordAddr > WORD_AW'(REG_SHI)) |=> rdData == '0); // R2

  AST_CTRL_MASK: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && (wordAddr == WORD_AW'(REG_CTRL)) |=> rdData[DATA_W-1:2] == '0); // R3

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R11

endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic rdSeen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one write cycle
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // driver: one read cycle, expected value pushed to scoreboard
  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    expItem_t it;
    it.val = e; it.tag = tag;
    expQ.push_back(it);
    busAddr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) rdSeen <= rdEn;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", rdData);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        chk(rdData, it.val, it.tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    chk({31'b0, irqOut}, 32'h0, "R1 irq after reset");
    for (int w = 0; w < 6; w++) rd(8'(w*4), 32'h0, "R1 reg after reset");
    wr(8'd16, 32'h0);
    rd(8'd16, 32'h0000FFFF, "R1 count low all ones");
    rd(8'd20, 32'h0000FFFF, "R1 count high all ones");

    // R3 / R4 control mask, start+stop together ends stopped
    wr(8'd4, 32'hFFFF_FFFF);
    rd(8'd4, 32'h3, "R3 control readback mask");
    rd(8'd0, 32'h0, "R4 start with stop stays stopped");
    rd(8'd5, 32'h3, "R2 low address bits ignored");

    // R2 unmapped words
    wr(8'd24, 32'h0);
    rd(8'd24, 32'h0, "R2 word6 reads zero");
    rd(8'd28, 32'h0, "R2 word7 reads zero");
    rd(8'd4, 32'h3, "R2 unmapped write ignored");

    // R7 period high keeps low 16 bits
    wr(8'd12, 32'hABCD_0001);
    rd(8'd12, 32'h1, "R7 period high truncated");
    wr(8'd12, 32'h0);
    wr(8'd8, 32'h4);

    // R5 / R6 one-shot with interrupt enabled, period 4
    wr(8'd4, 32'h5);
    idle(4);
    chk({31'b0, irqOut}, 32'h0, "R5 no timeout before period+1");
    idle(1);
    chk({31'b0, irqOut}, 32'h1, "R5 timeout at period+1");
    rd(8'd0, 32'h1, "R6 one-shot clears running");
    wr(8'd16, 32'h0);
    rd(8'd16, 32'h4, "R6 one-shot holds period");
    rd(8'd20, 32'h0, "R6 one-shot high half");

    // R9 status clear
    wr(8'd0, 32'h0);
    chk({31'b0, irqOut}, 32'h0, "R10 irq drops on clear");
    rd(8'd0, 32'h0, "R9 timeout cleared");

    // R10 enable gating
    wr(8'd4, 32'h4);
    idle(8);
    chk({31'b0, irqOut}, 32'h0, "R10 irq masked");
    rd(8'd0, 32'h1, "R10 flag set while masked");
    wr(8'd4, 32'h1);
    chk({31'b0, irqOut}, 32'h1, "R10 irq on enable");
    wr(8'd0, 32'hFFFF_FFFF);
    chk({31'b0, irqOut}, 32'h0, "R9 clear with any data");

    // R6 continuous
    wr(8'd4, 32'h7);
    idle(4);
    chk({31'b0, irqOut}, 32'h0, "R6 cont before first expiry");
    idle(1);
    chk({31'b0, irqOut}, 32'h1, "R6 cont first expiry");
    wr(8'd0, 32'h0);
    chk({31'b0, irqOut}, 32'h0, "R9 cleared while running");
    idle(3);
    chk({31'b0, irqOut}, 32'h0, "R6 cont before second expiry");
    idle(1);
    chk({31'b0, irqOut}, 32'h1, "R6 cont second expiry");
    rd(8'd0, 32'h3, "R6 still running after expiry");

    // R4 stop freezes count
    wr(8'd4, 32'hB);
    rd(8'd0, 32'h1, "R4 stop clears running");
    wr(8'd16, 32'h0);
    rd(8'd16, 32'h3, "R4 count at stop");
    idle(5);
    wr(8'd20, 32'h0);
    rd(8'd16, 32'h3, "R4 count frozen while stopped");

    // R8 live snapshot
    wr(8'd0, 32'h0);
    wr(8'd8, 32'd100);
    wr(8'd4, 32'h6);
    wr(8'd16, 32'h0);
    rd(8'd16, 32'd100, "R8 snapshot first step");
    wr(8'd20, 32'h0);
    rd(8'd16, 32'd98, "R8 snapshot via high word");
    rd(8'd20, 32'h0, "R8 snapshot high half");

    // R7 period write while running
    wr(8'd8, 32'h1234_0007);
    rd(8'd0, 32'h0, "R7 period write stops timer");
    rd(8'd8, 32'h7, "R7 period low truncated");
    wr(8'd16, 32'h0);
    rd(8'd16, 32'h7, "R7 count loaded with period");
    wr(8'd12, 32'h2);
    wr(8'd16, 32'h0);
    rd(8'd20, 32'h2, "R7 high half loads count");
    rd(8'd16, 32'h7, "R7 low half kept");

    idle(3);
    if (expQ.size() != 0) begin
      total++; bad++;
      $display("FAIL R11 missing read data actual=%0d expected=0", expQ.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule